// File: doc/BRIEF.md
# Latched Debiasing Entropy Sampler with Serial Output

This block turns a set of free-running oscillator signals into a stream of random bits sent out as asynchronous serial frames. Every system clock, each oscillator input is first caught in its own flop. Only then are the captured values XOR-reduced to a single bit, so fast runt pulses from an unclocked XOR tree never reach the result. A short register chain then re-times that bit to absorb metastability.

The re-timed bit is whitened before it is sent. At the start of each data-bit period, the stored random bit is updated by XOR with three things: the new sample, a fixed alternating mask that flips polarity on every byte, and the stored bit's own previous value. So each sample only decides whether the stored bit stays or inverts, and any steady bias in the sources is spread evenly over ones and zeros. The transmitter sends the stored bit as the data bit. Every eighth byte slot carries no data: it holds a long break on the line instead, so a receiver that lost sync cannot mistake random data for a start bit.

Top module: `ring_entropy_uart`

## Requirements
- R1: While reset is asserted the serial line is high. After reset is released it stays high for exactly one bit period, and then the first start bit begins.
- R2: A data slot lasts ten bit periods: one low start bit, eight data bits with the least significant bit first, and one high stop bit.
- R3: Each of the NUM_SRC oscillator inputs is registered before the reduction. Every input counts equally, so inverting any single input inverts the sampled bit.
- R4: At the start of data bit d (d = 0..7) the stored bit becomes stored XOR sample XOR mask[d], and the new stored value is driven on the line for that period. mask is 0x55 (bit d is set for even d) while the byte toggle is clear, and 0xAA while it is set. Reset clears the stored bit.
- R5: Reset clears the byte toggle, and the toggle inverts at the end of every data slot. With all inputs held low from reset, the first byte sent is 0x33 and the second is 0x66.
- R6: Slot counting starts at 0 after reset. Slots whose index modulo 8 is 7 are break slots: the line is low for ten bit periods and then high for one, and no sample is taken.
- R7: Oscillator values during a break slot have no effect on later output, and a break slot does not invert the byte toggle.
- R8: A bit period is BIT_DIV = round(CLK_HZ / BAUD) clock cycles, and the line changes only on bit-period boundaries counted from reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| osc_i | input | NUM_SRC | Free-running oscillator signals, asynchronous to clk_i |
| tx_o | output | 1 | Serial line, idle high |

## Verification
The bench builds the block with CLK_HZ = 8 MHz and BAUD = 1 MHz, which gives an eight-cycle bit period, and with two re-timing stages. With eight-cycle bits, several full rounds of eight slots, including three break slots, fit into a few thousand cycles. The short period also leaves room to change the oscillator inputs in the middle of every bit and still meet the deeper capture latency. The oscillator inputs are driven to zero, to one-hot patterns and to seeded random values. A bench model then predicts every line level, at both the first and the last cycle of each bit period.

// File: rtl/ent_pkg.sv
package ent_pkg;
   // Position of the stop bit within a data slot (start = 0, data = 1..8)
   localparam int unsigned STOP_POS  = 9;
   // Last position of a break slot: 0..9 low, 10 high for recovery
   localparam int unsigned BRK_LAST  = 10;
   localparam int unsigned POS_W     = 4;

   // Whitening mask bit: alternating pattern whose phase flips per byte.
   // pos_lsb is the LSB of the slot position (data bit d sits at position d+1).
   function automatic logic mask_bit(input logic pos_lsb, input logic tog);
      return pos_lsb ^ tog;
   endfunction
endpackage

// File: rtl/ent_baud_gen.sv
module ent_baud_gen #(
   parameter int unsigned DIV = 833
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/ent_sum_sync.sv
module ent_sum_sync #(
   parameter int unsigned NUM_SRC     = 9,
   parameter int unsigned SYNC_STAGES = 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_i,
   output logic               bit_o
);
   logic [NUM_SRC-1:0] cap_q;
   logic               fold;

   // One capture flop per oscillator, ahead of any combining logic
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_cap
      always_ff @(posedge clk_i) begin
         if (!rst_ni) cap_q[i] <= 1'b0;
         else         cap_q[i] <= src_i[i];
      end
   end

   assign fold = ^cap_q;

   if (SYNC_STAGES == 1) begin : g_sync_one
      logic s_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) s_q <= 1'b0;
         else         s_q <= fold;
      end
      assign bit_o = s_q;
   end else begin : g_sync_chain
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) s_q <= '0;
         else         s_q <= {s_q[SYNC_STAGES-2:0], fold};
      end
      assign bit_o = s_q[SYNC_STAGES-1];
   end
endmodule

// File: rtl/ent_frame_tx.sv
module ent_frame_tx
   import ent_pkg::*;
#(
   parameter int unsigned SLOT_W = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic sample_i,
   output logic tx_o,
   output logic tog_o
);
   localparam logic [SLOT_W-1:0] BRK_IDX = '1;

   logic             first_q, brk_q, tog_q, rnd_q, tx_q;
   logic [POS_W-1:0] pos_q, np;
   logic [SLOT_W-1:0] slot_q, ns;
   logic             at_end, nr;

   assign np     = pos_q + 1'b1;
   assign ns     = slot_q + 1'b1;
   assign at_end = brk_q ? (pos_q == POS_W'(BRK_LAST)) : (pos_q == POS_W'(STOP_POS));
   assign nr     = rnd_q ^ sample_i ^ mask_bit(np[0], tog_q);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         first_q <= 1'b1;
         brk_q   <= 1'b0;
         tog_q   <= 1'b0;
         rnd_q   <= 1'b0;
         tx_q    <= 1'b1;
         pos_q   <= '0;
         slot_q  <= '0;
      end else if (tick_i) begin
         if (first_q) begin
            first_q <= 1'b0;
            pos_q   <= '0;
            brk_q   <= (slot_q == BRK_IDX);
            tx_q    <= 1'b0;
         end else if (at_end) begin
            pos_q  <= '0;
            slot_q <= ns;
            brk_q  <= (ns == BRK_IDX);
            if (!brk_q) tog_q <= ~tog_q;
            tx_q   <= 1'b0;
         end else begin
            pos_q <= np;
            if (brk_q) begin
               tx_q <= (np == POS_W'(BRK_LAST));
            end else if (np < POS_W'(STOP_POS)) begin
               rnd_q <= nr;
               tx_q  <= nr;
            end else begin
               tx_q <= 1'b1;
            end
         end
      end
   end

   assign tx_o  = tx_q;
   assign tog_o = tog_q;
endmodule

// File: rtl/ring_entropy_uart.sv
module ring_entropy_uart #(
   parameter int unsigned NUM_SRC     = 9,
   parameter int unsigned CLK_HZ      = 8_000_000,
   parameter int unsigned BAUD        = 9600,
   parameter int unsigned SYNC_STAGES = 1,
   parameter int unsigned SLOT_W      = 3
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] osc_i,
   output logic               tx_o
);
   localparam int unsigned BIT_DIV = (CLK_HZ + BAUD / 2) / BAUD;

   if (BIT_DIV < 4) begin : g_bad_div
      $error("bit period must be at least 4 clocks");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("at least one oscillator input is required");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("at least one re-timing stage is required");
   end
   if (SLOT_W < 1) begin : g_bad_slot
      $error("slot counter needs at least one bit");
   end

   logic tick_w, sample_w, tog_w;

   ent_baud_gen #(.DIV(BIT_DIV)) u_baud (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_o(tick_w)
   );

   ent_sum_sync #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_sum (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .src_i (osc_i),
      .bit_o (sample_w)
   );

   ent_frame_tx #(.SLOT_W(SLOT_W)) u_tx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_w),
      .sample_i(sample_w),
      .tx_o    (tx_o),
      .tog_o   (tog_w)
   );
endmodule

// File: rtl/ring_entropy_uart_chk.sv
module ring_entropy_uart_chk #(
   parameter int unsigned BIT_DIV = 833
) (
   input logic clk_i,
   input logic rst_ni,
   input logic tx_i,
   input logic tick_i,
   input logic tog_i
);
   int unsigned age_q, low_q, high_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         age_q  <= 0;
         low_q  <= 0;
         high_q <= 0;
      end else begin
         age_q  <= age_q + 1;
         low_q  <= tx_i ? 0 : low_q + 1;
         high_q <= tx_i ? high_q + 1 : 0;
      end
   end

   // R1: line held high while in reset
   a_r1_idle_in_reset: assert property (@(posedge clk_i) !rst_ni |=> tx_i);

   // R8: line moves only on bit-period boundaries counted from reset release
   a_r8_edge_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(tx_i) |-> ((age_q % BIT_DIV) == 0));

   // R6: longest low stretch is the ten-period break
   a_r6_low_run_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      low_q <= 10 * BIT_DIV);

   // R2: every slot carries a low start bit, so a high stretch never exceeds nine periods
   a_r2_high_run_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      high_q <= 9 * BIT_DIV);

   // R5: byte toggle moves only on a bit-period tick
   a_r5_toggle_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(tog_i) |-> $past(tick_i));
endmodule

bind ring_entropy_uart ring_entropy_uart_chk #(.BIT_DIV(BIT_DIV)) u_chk (
   .clk_i (clk_i),
   .rst_ni(rst_ni),
   .tx_i  (tx_o),
   .tick_i(tick_w),
   .tog_i (tog_w)
);

// File: tb/ring_entropy_uart_test.sv
module ring_entropy_uart_test;
   localparam int unsigned NSRC = 9;
   localparam int unsigned DIV  = 8;    // round(8 MHz / 1 MHz)
   localparam int NPER = 250;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] osc = '0;
   logic            tx;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ring_entropy_uart #(
      .NUM_SRC(NSRC), .CLK_HZ(8_000_000), .BAUD(1_000_000),
      .SYNC_STAGES(2), .SLOT_W(3)
   ) uut (
      .clk_i(clk), .rst_ni(rst_n), .osc_i(osc), .tx_o(tx)
   );

   // Model state, from the requirements
   bit m_first = 1, m_brk = 0, m_tog = 0, m_rnd = 0, m_line = 1;
   int m_pos = 0, m_bcnt = 0, m_slot = 0;
   logic [7:0] rx;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit mask_of(input int d, input bit tog);
      bit even_set = (d % 2 == 0);   // 0x55 when toggle clear
      return tog ? !even_set : even_set;
   endfunction

   task automatic advance(input bit s);
      if (m_first) begin
         m_first = 0; m_pos = 0; m_brk = (m_bcnt == 7); m_line = 0;
      end else if (m_pos == (m_brk ? 10 : 9)) begin
         if (!m_brk) m_tog = !m_tog;
         m_bcnt = (m_bcnt + 1) % 8;
         m_brk  = (m_bcnt == 7);
         m_slot++;
         m_pos = 0; m_line = 0;
      end else begin
         m_pos++;
         if (m_brk)            m_line = (m_pos == 10);
         else if (m_pos <= 8) begin
            m_rnd  = m_rnd ^ s ^ mask_of(m_pos - 1, m_tog);
            m_line = m_rnd;
         end else              m_line = 1;
      end
   endtask

   function automatic string tag_of();
      if (m_brk) return "R6";
      if (m_pos == 0 || m_pos == 9) return "R2";
      if (m_slot == 2 || m_slot == 3) return "R3";
      if (m_slot % 8 == 0 && m_slot > 0) return "R7";
      return "R4";
   endfunction

   initial begin : main
      bit s;
      void'($urandom(32'h5EED_0042));
      repeat (5) @(negedge clk);
      check("R1 reset line", int'(tx), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after release", int'(tx), 1);
      repeat (DIV - 2) @(negedge clk);
      check("R1 idle last cycle", int'(tx), 1);
      s = ^osc;
      for (int j = 1; j <= NPER; j++) begin
         advance(s);
         @(negedge clk);
         check(tag_of(), int'(tx), int'(m_line));
         if (!m_brk && m_pos >= 1 && m_pos <= 8) rx[m_pos-1] = tx;
         if (!m_brk && m_pos == 9 && m_slot == 0) check("R5 first byte", int'(rx), 8'h33);
         if (!m_brk && m_pos == 9 && m_slot == 1) check("R5 second byte", int'(rx), 8'h66);
         repeat (2) @(negedge clk);
         if (m_slot < 2)                     osc = '0;
         else if (m_slot < 4)                osc = NSRC'(1) << (j % NSRC);
         else if (m_brk)                     osc = NSRC'($urandom) | NSRC'(1);
         else                                osc = NSRC'($urandom);
         repeat (DIV - 3) @(negedge clk);
         check("R8 bit held full period", int'(tx), int'(m_line));
         s = ^osc;
      end
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule